// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It runs two direction predictors side by side. The first is a table of 2-bit saturating counters indexed by bits of the branch address. The second is a table of 2-bit counters indexed by the branch address bits XOR-ed with a global history of recent branch outcomes. A third table of 2-bit selectors, also indexed by address bits, learns for each branch which of the two predictors has been right more often, and a mux driven by that selector produces the final answer.

A lookup is purely combinational: the fetch address goes in, and both component predictions and the selected prediction come out in the same cycle. When a branch resolves, the front end presents the branch address, the real outcome and the history value that was current when the branch was looked up. That update trains both counter tables and, when the two components disagreed, the selector. It also shifts the outcome into the global history register. The history register is an output so that fetch can save it with each branch.

Top module: `tourney_pred`

## Requirements
- R1: After reset every counter and every selector holds 01 and the global history is all zeros. Every lookup then reports not-taken from both components and from the final output.
- R2: The first component indexes its table with address bits [PC_LSB+IDX_W-1:PC_LSB], and its prediction is the MSB of that counter (1 = taken). All other address bits have no effect.
- R3: The second component indexes its table with the same address bits XOR-ed with the global history, which is zero-extended into the low bits. Its prediction is that counter's MSB.
- R4: The final prediction is the first component's when the selector at the address index has MSB 0 (values 00, 01). It is the second component's when the MSB is 1 (values 10, 11).
- R5: On every update, both component counters addressed by the update move one step toward the actual outcome: up for taken, down for not-taken. They saturate at 00 and 11, whichever component the selector chose.
- R6: On an update, the selector changes only if the two component predictions (read before the update) differ. It moves up when the second component was right and down when the first was right, saturating at 00 and 11.
- R7: On an update, the global history shifts left by one with the outcome entering bit 0. The second component's update index uses the supplied saved history, not the current register.
- R8: An update takes effect on the next clock edge, and the following lookups see it. With the update strobe low, no table and no history bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Fetch address to predict |
| lk_taken | output | 1 | Selected prediction |
| lk_local | output | 1 | Address-indexed component prediction |
| lk_global | output | 1 | History-hashed component prediction |
| ghist | output | HIST_W | Current global history |
| upd_valid | input | 1 | Update strobe for a resolved branch |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_hist | input | HIST_W | History saved at lookup time |

## Verification
Lookups are combinational, so all three predictions are due in the same cycle as the address. The bench drives the address on the falling edge and samples one nanosecond later. An update presented on a falling edge lands on the next rising edge. The bench therefore drops the strobe on the following falling edge, applies the update to its arithmetic model, and only then sweeps every table index through the lookup port and compares the history output. Cycles with the strobe low and arbitrary update fields are included, so any state change in those cycles would show up in the next sweep.

// File: rtl/tourney_pred.sv
module tourney_pred #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 8,
  parameter int HIST_W = 8,
  parameter int PC_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_taken,
  output logic              lk_local,
  output logic              lk_global,
  output logic [HIST_W-1:0] ghist,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken,
  input  logic [HIST_W-1:0] upd_hist
);
  localparam int N = 1 << IDX_W;

  logic [1:0] loc_t [N];
  logic [1:0] gsh_t [N];
  logic [1:0] cho_t [N];

  function automatic logic [1:0] bump(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    else    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  wire [IDX_W-1:0] lk_li = lk_pc[PC_LSB +: IDX_W];
  wire [IDX_W-1:0] lk_gi = lk_li ^ IDX_W'(ghist);
  wire [IDX_W-1:0] up_li = upd_pc[PC_LSB +: IDX_W];
  wire [IDX_W-1:0] up_gi = up_li ^ IDX_W'(upd_hist);

  assign lk_local  = loc_t[lk_li][1];
  assign lk_global = gsh_t[lk_gi][1];
  assign lk_taken  = cho_t[lk_li][1] ? lk_global : lk_local;

  wire up_lp = loc_t[up_li][1];
  wire up_gp = gsh_t[up_gi][1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        loc_t[i] <= 2'b01;
        gsh_t[i] <= 2'b01;
        cho_t[i] <= 2'b01;
      end
      ghist <= '0;
    end else if (upd_valid) begin
      loc_t[up_li] <= bump(loc_t[up_li], upd_taken);
      gsh_t[up_gi] <= bump(gsh_t[up_gi], upd_taken);
      if (up_lp != up_gp) cho_t[up_li] <= bump(cho_t[up_li], up_gp == upd_taken);
      ghist <= (ghist << 1) | HIST_W'(upd_taken);
    end
  end

  initial assert (HIST_W <= IDX_W && PC_LSB + IDX_W <= PC_W);

  assert_agree_final_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_local == lk_global) |-> (lk_taken == lk_local));

  assert_hist_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> ghist == {$past(ghist[HIST_W-2:0]), $past(upd_taken)});

  assert_idle_hist_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghist));

  assert_chooser_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && up_lp == up_gp) |=> cho_t[$past(up_li)] == $past(cho_t[up_li]));

  assert_local_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && loc_t[up_li] == 2'b11) |=> loc_t[$past(up_li)] == 2'b11);

  assert_local_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && loc_t[up_li] == 2'b00) |=> loc_t[$past(up_li)] == 2'b00);
endmodule

// File: tb/tourney_pred_test.sv
module tourney_pred_test;
  localparam int PC_W = 32, IDX_W = 4, HIST_W = 4, PC_LSB = 2;
  localparam int N = 1 << IDX_W;

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] lk_pc = '0, upd_pc = '0;
  logic lk_taken, lk_local, lk_global;
  logic [HIST_W-1:0] ghist, upd_hist = '0;
  logic upd_valid = 0, upd_taken = 0;

  always #4 clk = ~clk;

  tourney_pred #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .PC_LSB(PC_LSB)) uut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_local(lk_local),
    .lk_global(lk_global), .ghist(ghist), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_hist(upd_hist));

  int total = 0, bad = 0;
  int m_loc[N], m_gsh[N], m_cho[N];
  int m_hist;
  logic [31:0] lfsr = 32'h1d87_2a53;
  bit done = 0;

  function automatic int sat(int c, bit up);
    return up ? (c < 3 ? c + 1 : 3) : (c > 0 ? c - 1 : 0);
  endfunction

  function automatic logic [31:0] nxt(logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sweep(string tag);
    for (int i = 0; i < N; i++) begin
      int gi, el, eg, ef;
      @(negedge clk);
      lfsr = nxt(lfsr);
      lk_pc = {lfsr[31:PC_LSB+IDX_W], 4'(i), lfsr[PC_LSB-1:0]};
      #1;
      gi = i ^ m_hist;
      el = m_loc[i] >> 1;
      eg = m_gsh[gi] >> 1;
      ef = (m_cho[i] >> 1) ? eg : el;
      chk({tag, " R2 local"}, int'(lk_local), el);
      chk({tag, " R3 global"}, int'(lk_global), eg);
      chk({tag, " R4 final"}, int'(lk_taken), ef);
    end
    chk({tag, " R7 history"}, int'(ghist), m_hist);
  endtask

  task automatic update(int idx, bit t, int h);
    int gi, lp, gp;
    @(negedge clk);
    lfsr = nxt(lfsr);
    upd_pc = {lfsr[31:PC_LSB+IDX_W], 4'(idx), lfsr[PC_LSB-1:0]};
    upd_taken = t;
    upd_hist = 4'(h);
    upd_valid = 1;
    @(negedge clk);
    upd_valid = 0;
    gi = idx ^ h;
    lp = m_loc[idx] >> 1;
    gp = m_gsh[gi] >> 1;
    if (lp != gp) m_cho[idx] = sat(m_cho[idx], gp == int'(t));
    m_loc[idx] = sat(m_loc[idx], t);
    m_gsh[gi] = sat(m_gsh[gi], t);
    m_hist = ((m_hist << 1) | int'(t)) & (N - 1);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_loc[i] = 1; m_gsh[i] = 1; m_cho[i] = 1; end
    m_hist = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    sweep("reset R1");

    // R5 saturation upward then downward at one index, fixed history
    for (int k = 0; k < 5; k++) begin update(3, 1, 0); sweep("R5 up"); end
    for (int k = 0; k < 5; k++) begin update(3, 0, 0); sweep("R5 down"); end

    // R6: saved history differs from register so components split
    for (int k = 0; k < 6; k++) begin update(5, 1, 9); sweep("R6 train"); end
    for (int k = 0; k < 6; k++) begin update(5, 0, 2); sweep("R6 retrain"); end

    // R8: strobe low with busy update fields changes nothing
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      lfsr = nxt(lfsr);
      upd_pc = lfsr; upd_taken = lfsr[3]; upd_hist = lfsr[7:4];
    end
    sweep("R8 idle");

    // Mixed sweep: saved history is current history or arbitrary (R7)
    for (int k = 0; k < 600; k++) begin
      int idx, h;
      bit t;
      lfsr = nxt(lfsr);
      idx = int'(lfsr[3:0]) & (N - 1);
      t = lfsr[9] ^ lfsr[4] | (idx < 4);
      h = lfsr[11] ? m_hist : int'(lfsr[15:12]);
      update(idx, t, h);
      if (k % 4 == 0) sweep("mix R5 R6 R7");
    end
    sweep("final");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule